// File: doc/BRIEF.md
# Interrupt Accumulator Scan Controller

This block collects interrupt sources from up to 256 peripheral channels, each carrying up to eight sources. A source is latched when a raise pulse names its channel and source index, and it stays latched until software clears it through a per-channel clear write. Each channel has an enable bit, an owner field and a 12-bit peripheral id. A channel that is enabled, owned by the local owner and has at least one latched source sets one bit in a bank of 32-bit summary words. Bit k of word n stands for channel 32n + k.

A scan engine walks the summary words inside a channel window. The window runs from word (lowest registered channel >> 5) up to word (highest registered channel >> 5). Inside a word it takes the lowest pending channel first. Inside a channel it takes the lowest latched source first. Each pending source is offered as an encoded event on a valid/ready handshake. Software accepts the event and clears the source. A source that is not cleared is offered again on the next pass. The block also drives an interrupt line that stays high while any summary word inside the window is non-zero.

Top module: `irq_accum_scan`

## Requirements
- R1: After reset `irq_o` and `evt_valid_o` are 0, `min_ch_o` is 255 and `max_ch_o` is 0.
- R2: A raise pulse latches source `raise_src_i` of channel `raise_ch_i`. A config write with `cfg_sel_i` = 1 (clear) clears every latched source i of `cfg_ch_i` for which `cfg_wdata_i[i]` is 1 and leaves the other sources latched. If a raise and a clear hit the same source in the same cycle, the source stays latched.
- R3: A config write with `cfg_sel_i` = 0 sets the channel enable to `cfg_wdata_i[0]`. A disabled channel adds nothing to the summary, so it produces neither an interrupt nor an event.
- R4: A config write with `cfg_sel_i` = 3 sets the channel owner to `cfg_wdata_i[2:0]`. Only channels whose owner equals the local owner (default 0) add to the summary.
- R5: A config write with `cfg_sel_i` = 2 registers the channel. It stores `cfg_wdata_i[11:0]` as the peripheral id, lowers `min_ch_o` to the channel if the channel is below it, and raises `max_ch_o` to the channel if the channel is above it. Neither value moves in any other way.
- R6: `irq_o` is 1 exactly when some summary word with index in [`min_ch_o`>>5, `max_ch_o`>>5] is non-zero. A pending channel outside that word window raises no interrupt and no event.
- R7: Events are offered in ascending word order. Inside a word the lowest pending channel comes first, and inside a channel the lowest latched source comes first.
- R8: `evt_data_o` is {peripheral id[11:0], source index[7:0], channel[7:0]}.
- R9: One event is consumed on each cycle in which `evt_valid_o` and `evt_ready_i` are both 1. An offered event is withdrawn as soon as its source is cleared.
- R10: After a full pass the scan starts again while the interrupt is asserted, so a source that was accepted but not cleared is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_valid_i | input | 1 | Latch one source this cycle |
| raise_ch_i | input | 8 | Channel of the raised source |
| raise_src_i | input | 3 | Index of the raised source |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_sel_i | input | 2 | 0 enable, 1 clear, 2 register id, 3 owner |
| cfg_ch_i | input | 8 | Channel the config write targets |
| cfg_wdata_i | input | 16 | Config write data |
| evt_valid_o | output | 1 | Event offered |
| evt_ready_i | input | 1 | Event accepted |
| evt_data_o | output | 28 | {peripheral id, source index, channel} |
| irq_o | output | 1 | Some summary word in the window is non-zero |
| min_ch_o | output | 8 | Lowest registered channel |
| max_ch_o | output | 8 | Highest registered channel |

## Verification
The ordering tests use several source sets inside one channel and several channels spread over two summary words. Each set is latched while its channels are gated off and then released in one step, so a wrong bit priority or a wrong word order shows up as a wrong event sequence. The gating tests hold a pending channel back in three separate ways: by its enable bit, by a foreign owner, and by lying outside the registered window. In each case the bench then lifts the gate and expects the event to appear. Other patterns cover:
- clearing part of a channel's sources,
- a raise and a clear on the same source in the same cycle,
- clearing a source while its event is still offered,
- accepting an event without clearing it, which checks that it is offered again on the next pass.

// File: rtl/irq_accum_pkg.sv
package irq_accum_pkg;
  typedef enum logic [1:0] {
    CFG_EN  = 2'd0,
    CFG_CLR = 2'd1,
    CFG_REG = 2'd2,
    CFG_OWN = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_WORD = 2'd1,
    SC_CHAN = 2'd2,
    SC_EMIT = 2'd3
  } scan_st_e;
endpackage

// File: rtl/irq_stat_bank.sv
module irq_stat_bank
  import irq_accum_pkg::*;
#(
  parameter int NUM_CH = 256,
  parameter int SRC_N  = 8,
  parameter int PID_W  = 12,
  parameter int OWN_W  = 3,
  parameter int CFG_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int SRC_W = $clog2(SRC_N)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              raise_valid_i,
  input  logic [CH_W-1:0]                   raise_ch_i,
  input  logic [SRC_W-1:0]                  raise_src_i,
  input  logic                              cfg_we_i,
  input  cfg_sel_e                          cfg_sel_i,
  input  logic [CH_W-1:0]                   cfg_ch_i,
  input  logic [CFG_W-1:0]                  cfg_wdata_i,
  output logic [NUM_CH-1:0][SRC_N-1:0]      lat_o,
  output logic [NUM_CH-1:0]                 en_o,
  output logic [NUM_CH-1:0][OWN_W-1:0]      own_o,
  output logic [NUM_CH-1:0][PID_W-1:0]      pid_o,
  output logic [CH_W-1:0]                   min_ch_o,
  output logic [CH_W-1:0]                   max_ch_o
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             hit_cfg;
    logic [SRC_N-1:0] set_m, clr_m;

    assign hit_cfg = cfg_we_i && (cfg_ch_i == CH_W'(g));
    assign set_m   = (raise_valid_i && raise_ch_i == CH_W'(g)) ?
                     (SRC_N'(1) << raise_src_i) : '0;
    assign clr_m   = (hit_cfg && cfg_sel_i == CFG_CLR) ? cfg_wdata_i[SRC_N-1:0] : '0;

    // raise wins over a simultaneous clear of the same source
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lat_o[g] <= '0;
      else         lat_o[g] <= (lat_o[g] & ~clr_m) | set_m;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[g]  <= 1'b0;
        own_o[g] <= '0;
        pid_o[g] <= '0;
      end else if (hit_cfg) begin
        if (cfg_sel_i == CFG_EN)  en_o[g]  <= cfg_wdata_i[0];
        if (cfg_sel_i == CFG_OWN) own_o[g] <= cfg_wdata_i[OWN_W-1:0];
        if (cfg_sel_i == CFG_REG) pid_o[g] <= cfg_wdata_i[PID_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_ch_o <= CH_W'(NUM_CH - 1);
      max_ch_o <= '0;
    end else if (cfg_we_i && cfg_sel_i == CFG_REG) begin
      if (cfg_ch_i < min_ch_o) min_ch_o <= cfg_ch_i;
      if (cfg_ch_i > max_ch_o) max_ch_o <= cfg_ch_i;
    end
  end

endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int NUM_CH      = 256,
  parameter int SRC_N       = 8,
  parameter int OWN_W       = 3,
  parameter int LOCAL_OWNER = 0,
  parameter int WORD_W      = 32,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int WSH        = $clog2(WORD_W),
  localparam int NUM_W      = NUM_CH / WORD_W,
  localparam int WIDX_W     = CH_W - WSH
) (
  input  logic [NUM_CH-1:0][SRC_N-1:0]  lat_i,
  input  logic [NUM_CH-1:0]             en_i,
  input  logic [NUM_CH-1:0][OWN_W-1:0]  own_i,
  input  logic [CH_W-1:0]               min_ch_i,
  input  logic [CH_W-1:0]               max_ch_i,
  output logic [NUM_CH-1:0]             contrib_o,
  output logic [NUM_W-1:0][WORD_W-1:0]  words_o,
  output logic [WIDX_W-1:0]             first_w_o,
  output logic [WIDX_W-1:0]             last_w_o,
  output logic                          irq_o
);

  for (genvar n = 0; n < NUM_W; n++) begin : g_word
    for (genvar k = 0; k < WORD_W; k++) begin : g_bit
      localparam int CH = n * WORD_W + k;
      assign contrib_o[CH] = en_i[CH] && (own_i[CH] == OWN_W'(LOCAL_OWNER));
      assign words_o[n][k] = contrib_o[CH] && (|lat_i[CH]);
    end
  end

  assign first_w_o = min_ch_i[CH_W-1:WSH];
  assign last_w_o  = max_ch_i[CH_W-1:WSH];

  always_comb begin
    irq_o = 1'b0;
    for (int w = 0; w < NUM_W; w++) begin
      if (WIDX_W'(w) >= first_w_o && WIDX_W'(w) <= last_w_o && |words_o[w]) irq_o = 1'b1;
    end
  end

endmodule

// File: rtl/irq_scan_engine.sv
module irq_scan_engine
  import irq_accum_pkg::*;
#(
  parameter int NUM_CH   = 256,
  parameter int SRC_N    = 8,
  parameter int PID_W    = 12,
  parameter int WORD_W   = 32,
  parameter int EV_SRC_W = 8,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int SRC_W   = $clog2(SRC_N),
  localparam int WSH     = $clog2(WORD_W),
  localparam int NUM_W   = NUM_CH / WORD_W,
  localparam int WIDX_W  = CH_W - WSH,
  localparam int EVT_W   = PID_W + EV_SRC_W + CH_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_W-1:0][WORD_W-1:0]  words_i,
  input  logic [WIDX_W-1:0]             first_w_i,
  input  logic [WIDX_W-1:0]             last_w_i,
  input  logic                          irq_i,
  input  logic [NUM_CH-1:0][SRC_N-1:0]  lat_i,
  input  logic [NUM_CH-1:0]             contrib_i,
  input  logic [NUM_CH-1:0][PID_W-1:0]  pid_i,
  input  logic                          evt_ready_i,
  output logic                          evt_valid_o,
  output logic [EVT_W-1:0]              evt_data_o
);

  function automatic logic [WSH-1:0] low_w(input logic [WORD_W-1:0] v);
    low_w = '0;
    for (int i = WORD_W - 1; i >= 0; i--) if (v[i]) low_w = WSH'(i);
  endfunction

  function automatic logic [SRC_W-1:0] low_s(input logic [SRC_N-1:0] v);
    low_s = '0;
    for (int i = SRC_N - 1; i >= 0; i--) if (v[i]) low_s = SRC_W'(i);
  endfunction

  scan_st_e           st_q;
  logic [WIDX_W-1:0]  widx_q;
  logic [WORD_W-1:0]  word_pend_q;
  logic [CH_W-1:0]    cur_ch_q;
  logic [PID_W-1:0]   cur_pid_q;
  logic [SRC_N-1:0]   src_pend_q;

  logic [WSH-1:0]     lo_bit;
  logic [CH_W-1:0]    nxt_ch;
  logic [SRC_N-1:0]   eff_pend;
  logic [SRC_W-1:0]   lo_src;

  assign lo_bit   = low_w(word_pend_q);
  assign nxt_ch   = {widx_q, lo_bit};
  // live gating: a cleared or gated-off source is withdrawn at once
  assign eff_pend = src_pend_q & lat_i[cur_ch_q] & {SRC_N{contrib_i[cur_ch_q]}};
  assign lo_src   = low_s(eff_pend);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SC_IDLE;
      widx_q      <= '0;
      word_pend_q <= '0;
      cur_ch_q    <= '0;
      cur_pid_q   <= '0;
      src_pend_q  <= '0;
    end else begin
      unique case (st_q)
        SC_IDLE: if (irq_i) begin
          widx_q <= first_w_i;
          st_q   <= SC_WORD;
        end
        SC_WORD: begin
          word_pend_q <= words_i[widx_q];
          st_q        <= SC_CHAN;
        end
        SC_CHAN: begin
          if (word_pend_q == '0) begin
            if (widx_q >= last_w_i) st_q <= SC_IDLE;
            else begin
              widx_q <= widx_q + 1'b1;
              st_q   <= SC_WORD;
            end
          end else begin
            cur_ch_q            <= nxt_ch;
            cur_pid_q           <= pid_i[nxt_ch];
            src_pend_q          <= lat_i[nxt_ch];
            word_pend_q[lo_bit] <= 1'b0;
            st_q                <= SC_EMIT;
          end
        end
        SC_EMIT: begin
          if (eff_pend == '0)   st_q <= SC_CHAN;
          else if (evt_ready_i) src_pend_q[lo_src] <= 1'b0;
        end
        default: st_q <= SC_IDLE;
      endcase
    end
  end

  assign evt_valid_o = (st_q == SC_EMIT) && (eff_pend != '0);
  assign evt_data_o  = {cur_pid_q, EV_SRC_W'(lo_src), cur_ch_q};

endmodule

// File: rtl/irq_accum_scan.sv
module irq_accum_scan
  import irq_accum_pkg::*;
#(
  parameter int NUM_CH      = 256,
  parameter int SRC_N       = 8,
  parameter int PID_W       = 12,
  parameter int OWN_W       = 3,
  parameter int LOCAL_OWNER = 0,
  parameter int CFG_W       = 16,
  parameter int WORD_W      = 32,
  parameter int EV_SRC_W    = 8,
  localparam int CH_W       = $clog2(NUM_CH),
  localparam int SRC_W      = $clog2(SRC_N),
  localparam int WSH        = $clog2(WORD_W),
  localparam int NUM_W      = NUM_CH / WORD_W,
  localparam int WIDX_W     = CH_W - WSH,
  localparam int EVT_W      = PID_W + EV_SRC_W + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raise_valid_i,
  input  logic [CH_W-1:0]   raise_ch_i,
  input  logic [SRC_W-1:0]  raise_src_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic [EVT_W-1:0]  evt_data_o,
  output logic              irq_o,
  output logic [CH_W-1:0]   min_ch_o,
  output logic [CH_W-1:0]   max_ch_o
);

  logic [NUM_CH-1:0][SRC_N-1:0]  lat_q;
  logic [NUM_CH-1:0]             en_q;
  logic [NUM_CH-1:0][OWN_W-1:0]  own_q;
  logic [NUM_CH-1:0][PID_W-1:0]  pid_q;
  logic [NUM_CH-1:0]             contrib;
  logic [NUM_W-1:0][WORD_W-1:0]  words;
  logic [WIDX_W-1:0]             first_w, last_w;

  irq_stat_bank #(
    .NUM_CH(NUM_CH), .SRC_N(SRC_N), .PID_W(PID_W), .OWN_W(OWN_W), .CFG_W(CFG_W)
  ) bank_i (
    .clk_i, .rst_ni, .raise_valid_i, .raise_ch_i, .raise_src_i,
    .cfg_we_i, .cfg_sel_i(cfg_sel_e'(cfg_sel_i)), .cfg_ch_i, .cfg_wdata_i,
    .lat_o(lat_q), .en_o(en_q), .own_o(own_q), .pid_o(pid_q),
    .min_ch_o, .max_ch_o
  );

  irq_summary #(
    .NUM_CH(NUM_CH), .SRC_N(SRC_N), .OWN_W(OWN_W),
    .LOCAL_OWNER(LOCAL_OWNER), .WORD_W(WORD_W)
  ) sum_i (
    .lat_i(lat_q), .en_i(en_q), .own_i(own_q),
    .min_ch_i(min_ch_o), .max_ch_i(max_ch_o),
    .contrib_o(contrib), .words_o(words),
    .first_w_o(first_w), .last_w_o(last_w), .irq_o
  );

  irq_scan_engine #(
    .NUM_CH(NUM_CH), .SRC_N(SRC_N), .PID_W(PID_W),
    .WORD_W(WORD_W), .EV_SRC_W(EV_SRC_W)
  ) scan_i (
    .clk_i, .rst_ni, .words_i(words), .first_w_i(first_w), .last_w_i(last_w),
    .irq_i(irq_o), .lat_i(lat_q), .contrib_i(contrib), .pid_i(pid_q),
    .evt_ready_i, .evt_valid_o, .evt_data_o
  );

endmodule

// File: rtl/irq_accum_scan_chk.sv
module irq_accum_scan_chk #(
  parameter int NUM_CH   = 256,
  parameter int SRC_N    = 8,
  parameter int CFG_W    = 16,
  parameter int EVT_W    = 28,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int SRC_W   = $clog2(SRC_N)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         raise_valid_i,
  input logic [CH_W-1:0]              raise_ch_i,
  input logic [SRC_W-1:0]             raise_src_i,
  input logic                         cfg_we_i,
  input logic [1:0]                   cfg_sel_i,
  input logic [CH_W-1:0]              cfg_ch_i,
  input logic [CFG_W-1:0]             cfg_wdata_i,
  input logic                         evt_valid_o,
  input logic [EVT_W-1:0]             evt_data_o,
  input logic                         irq_o,
  input logic [CH_W-1:0]              min_ch_o,
  input logic [CH_W-1:0]              max_ch_o,
  input logic [NUM_CH-1:0][SRC_N-1:0] lat_q
);

  logic [CH_W-1:0] ev_ch;
  logic [7:0]      ev_src;
  assign ev_ch  = evt_data_o[CH_W-1:0];
  assign ev_src = evt_data_o[CH_W+7:CH_W];

  assert_evt_has_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> irq_o);

  assert_evt_src_live_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> lat_q[ev_ch][ev_src[SRC_W-1:0]]);

  assert_evt_src_field_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_valid_o |-> (ev_src < 8'(SRC_N)));

  assert_min_never_rises_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_we_i && cfg_sel_i == 2'd2) |=> min_ch_o == $past(min_ch_o));

  assert_max_never_falls_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> max_ch_o >= $past(max_ch_o));

  assert_raise_latches_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_valid_i |=> lat_q[$past(raise_ch_i)][$past(raise_src_i)]);

  assert_clear_takes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == 2'd1 && !(raise_valid_i && raise_ch_i == cfg_ch_i))
    |=> (lat_q[$past(cfg_ch_i)] & $past(cfg_wdata_i[SRC_N-1:0])) == '0);

endmodule

bind irq_accum_scan irq_accum_scan_chk #(
  .NUM_CH(NUM_CH), .SRC_N(SRC_N), .CFG_W(CFG_W), .EVT_W(EVT_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .raise_valid_i(raise_valid_i),
  .raise_ch_i(raise_ch_i), .raise_src_i(raise_src_i), .cfg_we_i(cfg_we_i),
  .cfg_sel_i(cfg_sel_i), .cfg_ch_i(cfg_ch_i), .cfg_wdata_i(cfg_wdata_i),
  .evt_valid_o(evt_valid_o), .evt_data_o(evt_data_o), .irq_o(irq_o),
  .min_ch_o(min_ch_o), .max_ch_o(max_ch_o), .lat_q(lat_q)
);

// File: tb/irq_accum_scan_tb_top.sv
module irq_accum_scan_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        raise_valid_i = 1'b0;
  logic [7:0]  raise_ch_i = '0;
  logic [2:0]  raise_src_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [7:0]  cfg_ch_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        evt_valid_o;
  logic        evt_ready_i = 1'b0;
  logic [27:0] evt_data_o;
  logic        irq_o;
  logic [7:0]  min_ch_o, max_ch_o;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [1:0] S_EN = 2'd0, S_CLR = 2'd1, S_REG = 2'd2, S_OWN = 2'd3;

  always #5 clk_i = ~clk_i;

  irq_accum_scan dut_i (
    .clk_i, .rst_ni, .raise_valid_i, .raise_ch_i, .raise_src_i,
    .cfg_we_i, .cfg_sel_i, .cfg_ch_i, .cfg_wdata_i,
    .evt_valid_o, .evt_ready_i, .evt_data_o, .irq_o, .min_ch_o, .max_ch_o
  );

  function automatic logic [27:0] mk(input logic [11:0] pid, input int src, input int ch);
    mk = {pid, 8'(src), 8'(ch)};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input int ch, input logic [15:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_ch_i = 8'(ch); cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic raise(input int ch, input int src);
    raise_valid_i = 1'b1; raise_ch_i = 8'(ch); raise_src_i = 3'(src);
    @(negedge clk_i);
    raise_valid_i = 1'b0;
  endtask

  task automatic take(input logic [27:0] exp, input string tag, input bit clr);
    int n = 0;
    while (!evt_valid_o && n < 200) begin @(negedge clk_i); n++; end
    check(evt_valid_o, {tag, " valid"}, 32'(evt_valid_o), 32'd1);
    check(evt_data_o == exp, {tag, " data"}, 32'(evt_data_o), 32'(exp));
    evt_ready_i = 1'b1;
    @(negedge clk_i);
    evt_ready_i = 1'b0;
    if (clr) cfg_wr(S_CLR, exp[7:0], 16'(1) << exp[15:8]);
  endtask

  task automatic quiet(input string tag);
    repeat (20) @(negedge clk_i);
    check(!irq_o, {tag, " irq low"}, 32'(irq_o), 32'd0);
    check(!evt_valid_o, {tag, " no event"}, 32'(evt_valid_o), 32'd0);
  endtask

  task automatic t_reset;
    check(!irq_o, "R1 irq", 32'(irq_o), 0);
    check(!evt_valid_o, "R1 valid", 32'(evt_valid_o), 0);
    check(min_ch_o == 8'd255, "R1 min", 32'(min_ch_o), 255);
    check(max_ch_o == 8'd0, "R1 max", 32'(max_ch_o), 0);
  endtask

  task automatic t_single;
    cfg_wr(S_REG, 5, 16'h123);
    check(min_ch_o == 8'd5 && max_ch_o == 8'd5, "R5 first reg", {min_ch_o, max_ch_o}, {8'd5, 8'd5});
    raise(5, 3);
    raise(5, 1);
    cfg_wr(S_EN, 5, 16'h1);
    take(mk(12'h123, 1, 5), "R7 R8 ch5 src1", 1'b1);
    take(mk(12'h123, 3, 5), "R7 R8 ch5 src3", 1'b1);
    quiet("R2 single cleared");
  endtask

  task automatic t_multi;
    cfg_wr(S_REG, 40, 16'hA40);
    cfg_wr(S_REG, 33, 16'h033);
    cfg_wr(S_REG, 3, 16'h003);
    raise(40, 0); raise(33, 7); raise(3, 2); raise(3, 0);
    cfg_wr(S_EN, 3, 16'h1);
    cfg_wr(S_EN, 33, 16'h1);
    cfg_wr(S_EN, 40, 16'h1);
    take(mk(12'h003, 0, 3), "R7 multi 1", 1'b1);
    take(mk(12'h003, 2, 3), "R7 multi 2", 1'b1);
    take(mk(12'h033, 7, 33), "R7 multi 3", 1'b1);
    take(mk(12'hA40, 0, 40), "R7 multi 4", 1'b1);
    quiet("R6 multi cleared");
  endtask

  task automatic t_gate;
    cfg_wr(S_REG, 12, 16'h00C);
    raise(12, 4);
    quiet("R3 disabled");
    cfg_wr(S_EN, 12, 16'h1);
    take(mk(12'h00C, 4, 12), "R3 enabled", 1'b1);
    quiet("R3 cleared");
  endtask

  task automatic t_owner;
    cfg_wr(S_REG, 20, 16'h014);
    cfg_wr(S_OWN, 20, 16'h1);
    cfg_wr(S_EN, 20, 16'h1);
    raise(20, 5);
    quiet("R4 foreign owner");
    cfg_wr(S_OWN, 20, 16'h0);
    take(mk(12'h014, 5, 20), "R4 local owner", 1'b1);
    quiet("R4 cleared");
  endtask

  task automatic t_range;
    cfg_wr(S_EN, 250, 16'h1);
    raise(250, 1);
    quiet("R6 outside window");
    cfg_wr(S_REG, 250, 16'hFA0);
    check(min_ch_o == 8'd3 && max_ch_o == 8'd250, "R5 window", {min_ch_o, max_ch_o}, {8'd3, 8'd250});
    take(mk(12'hFA0, 1, 250), "R6 inside window", 1'b1);
    quiet("R6 cleared");
  endtask

  task automatic t_clear_mask;
    cfg_wr(S_EN, 5, 16'h0);
    raise(5, 0); raise(5, 2); raise(5, 6);
    cfg_wr(S_CLR, 5, 16'h0041);
    cfg_wr(S_EN, 5, 16'h1);
    take(mk(12'h123, 2, 5), "R2 partial clear", 1'b1);
    quiet("R2 partial done");
  endtask

  task automatic t_same_cycle;
    cfg_wr(S_EN, 5, 16'h0);
    raise_valid_i = 1'b1; raise_ch_i = 8'd5; raise_src_i = 3'd7;
    cfg_we_i = 1'b1; cfg_sel_i = S_CLR; cfg_ch_i = 8'd5; cfg_wdata_i = 16'h0080;
    @(negedge clk_i);
    raise_valid_i = 1'b0; cfg_we_i = 1'b0;
    cfg_wr(S_EN, 5, 16'h1);
    take(mk(12'h123, 7, 5), "R2 raise beats clear", 1'b1);
    quiet("R2 same cycle done");
  endtask

  task automatic t_rescan;
    cfg_wr(S_EN, 5, 16'h0);
    raise(5, 4);
    cfg_wr(S_EN, 5, 16'h1);
    take(mk(12'h123, 4, 5), "R10 first pass", 1'b0);
    take(mk(12'h123, 4, 5), "R10 second pass", 1'b1);
    quiet("R10 done");
  endtask

  task automatic t_withdraw;
    int n = 0;
    raise(5, 1);
    while (!evt_valid_o && n < 200) begin @(negedge clk_i); n++; end
    check(evt_data_o == mk(12'h123, 1, 5), "R9 offered", 32'(evt_data_o), 32'(mk(12'h123, 1, 5)));
    cfg_wr(S_CLR, 5, 16'h0002);
    check(!evt_valid_o, "R9 withdrawn", 32'(evt_valid_o), 0);
    quiet("R9 done");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_multi();
    t_gate();
    t_owner();
    t_range();
    t_clear_mask();
    t_same_cycle();
    t_rescan();
    t_withdraw();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule